// File: doc/BRIEF.md
# PPS-Latched Timekeeper

This block keeps a running time made of a seconds count and a sub-second tick count. The tick count advances on every clock. When it reaches the configured number of ticks per second it returns to zero and the seconds count steps up. Software changes the time through a plain write port with four word addresses: a pending seconds value, a pending ticks value, a flags word and an arm word.

Writing the arm word schedules a load of the pending values into the live counters. A 1 in bit 0 applies the load at once. A 0 holds it until the next pulse-per-second event. The PPS event comes from one of two inputs: a local connector pin or a link pin from a neighbouring unit. Each input passes through a two-flop synchronizer, and the event is taken on the rising or on the falling edge, as the flags select. A one-cycle pulse output marks each detected event, so other logic can align to it.

The port carries single-word control writes with no data stream, so it has no valid/ready handshake. A write is taken on any clock edge where the write strobe is high, and it is never stalled.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset, seconds and ticks read 0 and the pulse output is low. The flags default to falling edge on the connector input, and no load is armed.
- R2: With no load, ticks rise by 1 on every clock. When ticks equal TICKS_PER_SEC-1, the next clock sets ticks to 0 and adds 1 to seconds.
- R3: Word address 0 writes the pending seconds and address 1 writes the pending ticks. Address 2 writes the flags and address 3 writes the arm word. Writing the pending values alone leaves the live time counting undisturbed.
- R4: A write to address 3 with bit 0 = 1 loads the pending values on the clock edge after the one that takes the write. A pending ticks value of TICKS_PER_SEC or more loads as 0.
- R5: A write to address 3 with bit 0 = 0 arms a load. The load takes effect on the clock edge that ends the pulse cycle of the next detected PPS event, and until then counting continues normally.
- R6: Flag bit 0 picks the active edge: 1 means rising, 0 means falling. An edge of the other direction produces no pulse and no load.
- R7: Flag bit 1 picks the source: 0 is the connector input and 1 is the link input. Activity on the other input produces no pulse and no load.
- R8: pps_pulse_o is high for exactly one cycle for each detected edge. That cycle follows the second clock edge that samples the new level of the selected input.
- R9: Each arm loads the time exactly once. Later PPS events still pulse but do not reload until the arm word is written again.
- R10: If an armed load falls in the same cycle as a seconds rollover, the loaded values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 2 | Word address: 0 seconds, 1 ticks, 2 flags, 3 arm |
| reg_wdata | input | DATA_W | Write data |
| pps_conn_i | input | 1 | Asynchronous PPS from the local connector |
| pps_link_i | input | 1 | Asynchronous PPS from the neighbouring unit |
| time_secs_o | output | DATA_W | Live seconds count |
| time_ticks_o | output | DATA_W | Live sub-second tick count |
| pps_pulse_o | output | 1 | One-cycle mark of a detected PPS edge |

## Verification
The bound checker watches the counting law on every cycle. It checks the tick range, the steady increment and the rollover into seconds. It also checks that every load puts the last written pending values on the outputs, including a load that meets a rollover. Further every-cycle checks are that an immediate arm loads one cycle after its write, that a load does not repeat without a fresh arm, and that the pulse never lasts two cycles. Only the bench scenarios can show the parts that depend on the PPS inputs. These are which edge direction and which input are honoured, the two-cycle synchronizer delay before the pulse, and that an armed load waits through wrong-edge and wrong-source activity.

// File: rtl/tk_pkg.sv
package tk_pkg;
  typedef enum logic [1:0] {
    TK_REG_SECS  = 2'd0,
    TK_REG_TICKS = 2'd1,
    TK_REG_FLAGS = 2'd2,
    TK_REG_ARM   = 2'd3
  } tk_reg_e;

  typedef struct packed {
    logic use_link;   // bit 1: source select
    logic on_rise;    // bit 0: edge select
  } tk_flags_t;
endpackage

// File: rtl/tk_pps_front.sv
module tk_pps_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pps_conn_i,
  input  logic            pps_link_i,
  input  tk_pkg::tk_flags_t flags_i,
  output logic            pps_edge_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] synced;
  logic               picked;
  logic               picked_q;

  assign raw = {pps_link_i, pps_conn_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[SYNC_STAGES-1];
  end

  assign picked = flags_i.use_link ? synced[1] : synced[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) picked_q <= 1'b0;
    else        picked_q <= picked;
  end

  always_comb begin
    if (flags_i.on_rise) pps_edge_o = picked & ~picked_q;
    else                 pps_edge_o = ~picked & picked_q;
  end
endmodule

// File: rtl/tk_load_ctrl.sv
module tk_load_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pps_edge_i,
  output logic [DATA_W-1:0] pend_secs_o,
  output logic [DATA_W-1:0] pend_ticks_o,
  output tk_pkg::tk_flags_t flags_o,
  output logic              load_o
);
  import tk_pkg::*;

  logic now_q;
  logic armed_q;
  logic arm_wr;

  assign arm_wr = wr_en_i && (tk_reg_e'(wr_addr_i) == TK_REG_ARM);
  assign load_o = armed_q && (now_q || pps_edge_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_secs_o  <= '0;
      pend_ticks_o <= '0;
      flags_o      <= '0;
    end else if (wr_en_i) begin
      case (tk_reg_e'(wr_addr_i))
        TK_REG_SECS:  pend_secs_o  <= wr_data_i;
        TK_REG_TICKS: pend_ticks_o <= wr_data_i;
        TK_REG_FLAGS: flags_o      <= tk_flags_t'(wr_data_i[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_wr) begin
      now_q   <= wr_data_i[0];
      armed_q <= 1'b1;
    end else if (load_o) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int          DATA_W        = 32,
  parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_secs_i,
  input  logic [DATA_W-1:0] load_ticks_i,
  output logic [DATA_W-1:0] secs_o,
  output logic [DATA_W-1:0] ticks_o
);
  localparam logic [DATA_W-1:0] TPS_V  = DATA_W'(TICKS_PER_SEC);
  localparam logic [DATA_W-1:0] LAST_T = DATA_W'(TICKS_PER_SEC - 1);

  logic [DATA_W-1:0] safe_ticks;
  assign safe_ticks = (load_ticks_i < TPS_V) ? load_ticks_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_o  <= '0;
      ticks_o <= '0;
    end else if (load_i) begin
      secs_o  <= load_secs_i;
      ticks_o <= safe_ticks;
    end else if (ticks_o == LAST_T) begin
      secs_o  <= secs_o + 1'b1;
      ticks_o <= '0;
    end else begin
      ticks_o <= ticks_o + 1'b1;
    end
  end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
  parameter int          DATA_W        = 32,
  parameter int unsigned TICKS_PER_SEC = 100_000_000,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              pps_conn_i,
  input  logic              pps_link_i,
  output logic [DATA_W-1:0] time_secs_o,
  output logic [DATA_W-1:0] time_ticks_o,
  output logic              pps_pulse_o
);
  tk_pkg::tk_flags_t flags;
  logic              pps_edge;
  logic              load_fire;
  logic [DATA_W-1:0] pend_secs;
  logic [DATA_W-1:0] pend_ticks;

  tk_pps_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .pps_conn_i (pps_conn_i),
    .pps_link_i (pps_link_i),
    .flags_i    (flags),
    .pps_edge_o (pps_edge)
  );

  tk_load_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (reg_wr_en),
    .wr_addr_i    (reg_addr),
    .wr_data_i    (reg_wdata),
    .pps_edge_i   (pps_edge),
    .pend_secs_o  (pend_secs),
    .pend_ticks_o (pend_ticks),
    .flags_o      (flags),
    .load_o       (load_fire)
  );

  tk_counter #(.DATA_W(DATA_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_fire),
    .load_secs_i  (pend_secs),
    .load_ticks_i (pend_ticks),
    .secs_o       (time_secs_o),
    .ticks_o      (time_ticks_o)
  );

  assign pps_pulse_o = pps_edge;
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int          DATA_W        = 32,
  parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] time_secs_o,
  input logic [DATA_W-1:0] time_ticks_o,
  input logic              pps_pulse_o,
  input logic              load_fire
);
  localparam logic [DATA_W-1:0] TPS_V  = DATA_W'(TICKS_PER_SEC);
  localparam logic [DATA_W-1:0] LAST_T = DATA_W'(TICKS_PER_SEC - 1);

  logic [DATA_W-1:0] sh_secs;
  logic [DATA_W-1:0] sh_ticks;
  logic [DATA_W-1:0] sh_eff_ticks;
  logic              imm_wr_q;
  logic              arm_wr;
  logic              flag_wr;

  assign arm_wr       = reg_wr_en && (reg_addr == 2'd3);
  assign flag_wr      = reg_wr_en && (reg_addr == 2'd2);
  assign sh_eff_ticks = (sh_ticks < TPS_V) ? sh_ticks : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_secs  <= '0;
      sh_ticks <= '0;
      imm_wr_q <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == 2'd0) sh_secs  <= reg_wdata;
      if (reg_wr_en && reg_addr == 2'd1) sh_ticks <= reg_wdata;
      imm_wr_q <= arm_wr && reg_wdata[0];
    end
  end

  assert_tick_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    time_ticks_o < TPS_V);

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && time_ticks_o != LAST_T) |=>
      (time_ticks_o == $past(time_ticks_o) + 1'b1) && (time_secs_o == $past(time_secs_o)));

  assert_rollover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fire && time_ticks_o == LAST_T) |=>
      (time_ticks_o == '0) && (time_secs_o == $past(time_secs_o) + 1'b1));

  // R10: a load takes the pending values even on a rollover cycle
  assert_load_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (time_secs_o == $past(sh_secs)) && (time_ticks_o == $past(sh_eff_ticks)));

  assert_imm_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    imm_wr_q |=> (time_secs_o == $past(sh_secs)) && (time_ticks_o == $past(sh_eff_ticks)));

  assert_once_per_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !arm_wr) |=> !load_fire);

  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_pulse_o && !flag_wr) |=> !pps_pulse_o);
endmodule

bind pps_timekeeper tk_checker #(.DATA_W(DATA_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .time_secs_o  (time_secs_o),
  .time_ticks_o (time_ticks_o),
  .pps_pulse_o  (pps_pulse_o),
  .load_fire    (load_fire)
);

// File: tb/pps_timekeeper_bench.sv
module pps_timekeeper_bench;
  localparam int unsigned TPS = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic        pin_conn = 1'b0;
  logic        pin_link = 1'b0;
  logic [31:0] secs;
  logic [31:0] ticks;
  logic        pulse;

  always #2 clk = ~clk;

  pps_timekeeper #(.DATA_W(32), .TICKS_PER_SEC(TPS)) u_pps_timekeeper (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (wr_en),
    .reg_addr     (addr),
    .reg_wdata    (wdata),
    .pps_conn_i   (pin_conn),
    .pps_link_i   (pin_link),
    .time_secs_o  (secs),
    .time_ticks_o (ticks),
    .pps_pulse_o  (pulse)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] ref_s = 0, ref_t = 0, pend_s = 0, pend_t = 0;

  function automatic logic [63:0] adv(input logic [31:0] s, input logic [31:0] t);
    if (t == TPS - 1) return {s + 32'd1, 32'd0};
    return {s, t + 32'd1};
  endfunction

  function automatic logic [31:0] eff_ticks(input logic [31:0] t);
    return (t < TPS) ? t : 32'd0;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk_time(input string req);
    checks++;
    if (secs !== ref_s || ticks !== ref_t) begin
      errors++;
      $display("FAIL %s: time %0d.%0d expected %0d.%0d", req, secs, ticks, ref_s, ref_t);
    end
  endtask

  task automatic chk_pulse(input string req, input logic exp);
    checks++;
    if (pulse !== exp) begin
      errors++;
      $display("FAIL %s: pps_pulse_o %0b expected %0b", req, pulse, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    {ref_s, ref_t} = adv(ref_s, ref_t);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step();
      chk_time(req);
      chk_pulse(req, 1'b0);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    if (a == 2'd0) pend_s = d;
    if (a == 2'd1) pend_t = d;
    step();
    wr_en = 1'b0;
    chk_time("R3");
  endtask

  task automatic set_pin(input bit use_link, input logic v);
    if (use_link) pin_link = v; else pin_conn = v;
  endtask

  task automatic load_now();
    wr(2'd3, 32'd1);
    @(negedge clk);
    ref_s = pend_s; ref_t = eff_ticks(pend_t);
    chk_time("R4");
  endtask

  // fire one selected edge; align >= 0 delays firing until ref_t matches it
  task automatic pps_event(input bit use_link, input bit rise, input int align, input bit expect_load);
    if (!rise) begin
      set_pin(use_link, 1'b1);
      run(4, "R6");
    end
    if (align >= 0) begin
      while (ref_t != 32'(align)) begin
        step();
        chk_time("R5");
      end
    end
    set_pin(use_link, rise);
    step(); chk_time("R5"); chk_pulse("R8", 1'b0);
    step(); chk_time("R5"); chk_pulse("R8", 1'b1);
    @(negedge clk);
    if (expect_load) begin
      ref_s = pend_s; ref_t = eff_ticks(pend_t);
      chk_time("R5");
    end else begin
      {ref_s, ref_t} = adv(ref_s, ref_t);
      chk_time("R9");
    end
    chk_pulse("R8", 1'b0);
    if (rise) begin
      set_pin(use_link, 1'b0);
      run(4, "R6");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    int seed_v;
    logic [1:0] fl;
    logic [31:0] s, t;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_time("R1");
    chk_pulse("R1", 1'b0);
    // R2: free counting across two rollovers
    run(2 * TPS + 5, "R2");
    // R3: pending writes do not disturb live time
    wr(2'd0, 32'd500);
    wr(2'd1, 32'd7);
    run(3, "R3");
    // R1/R5: default flags are falling edge on the connector input
    wr(2'd3, 32'd0);
    run(6, "R5");
    pps_event(1'b0, 1'b0, -1, 1'b1);
    // R9: a second edge without re-arm pulses but does not reload
    pps_event(1'b0, 1'b0, -1, 1'b0);
    // R4: immediate load, and out-of-range ticks load as 0
    wr(2'd0, 32'd77); wr(2'd1, 32'd12);
    load_now();
    run(3, "R4");
    wr(2'd1, 32'(TPS + 9));
    load_now();
    run(2, "R4");
    // R4: load TPS-1 so rollover follows immediately
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'(TPS - 1));
    load_now();
    run(2, "R2");
    // R6: rising edge selection on the connector
    wr(2'd2, 32'd1);
    wr(2'd0, 32'd900); wr(2'd1, 32'd3);
    wr(2'd3, 32'd0);
    pps_event(1'b0, 1'b1, -1, 1'b1);
    // R7: link selected, connector activity ignored
    wr(2'd2, 32'd3);
    wr(2'd0, 32'd1234); wr(2'd1, 32'd20);
    wr(2'd3, 32'd0);
    pin_conn = 1'b1; run(5, "R7");
    pin_conn = 1'b0; run(5, "R7");
    pps_event(1'b1, 1'b1, -1, 1'b1);
    // R10: armed load lands on the rollover cycle
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd42); wr(2'd1, 32'd5);
    wr(2'd3, 32'd0);
    pin_conn = 1'b1; run(4, "R6");
    while (ref_t != TPS - 3) begin step(); chk_time("R10"); end
    pin_conn = 1'b0;
    step(); chk_time("R10");
    step(); chk_time("R10"); chk_pulse("R8", 1'b1);
    @(negedge clk);
    ref_s = pend_s; ref_t = pend_t;
    chk_time("R10");
    run(3, "R10");
    // random mix of flags, values and load modes
    for (int i = 0; i < 14; i++) begin
      fl = 2'($urandom % 4);
      wr(2'd2, {30'd0, fl});
      s = $urandom;
      t = $urandom % TPS;
      if (i == 3) t = TPS - 1;
      if (i == 6) t = TPS + 3;
      wr(2'd0, s);
      wr(2'd1, t);
      if ($urandom % 2 == 0) begin
        load_now();
        run(1 + int'($urandom % 5), "R4");
      end else begin
        wr(2'd3, 32'd0);
        set_pin(!fl[1], 1'b1); run(4, "R7");
        set_pin(!fl[1], 1'b0); run(4, "R7");
        pps_event(fl[1], fl[0], -1, 1'b1);
        run(1 + int'($urandom % 5), "R9");
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule